// File: doc/BRIEF.md
# Multi-Channel Interrupt Status Aggregator

This block gathers interrupt causes from a configurable number of copy channels and folds them into one shared interrupt line. Each channel keeps a status register with one copy-done bit, a group of watermark bits and a group of error bits. Cause pulses from the channel logic set these bits. Software clears them by writing ones. Two enable registers per channel decide which latched causes count toward an interrupt. The host enable register covers copy-done and watermark. The auxiliary enable register covers errors.

A summary word holds one bit per channel. A bit is set when its channel has at least one latched cause whose enable is set. The combined interrupt output is a registered OR of that word. A single handler can therefore read the summary, visit the flagged channels in ascending order, and clear the causes it has handled. It clears copy-done causes before watermark causes. All register access goes through a plain address/data port. Writes are strobed and reads are combinational.

The address is `{channel, select}`. Select codes are: 0 for host enable, 1 for auxiliary enable, 2 for status and 3 for summary. Status bit layout is: bit 0 copy-done, bits [WM_W:1] watermark, and bits [WM_W+ERR_W:WM_W+1] error. The default layout is bit 0, bits [4:1] and bits [7:5].

Top module: `intr_aggregator`

## Requirements
- R1: After reset, every enable and status register reads 0, the summary word is 0 and `irq` is 0.
- R2: A cause pulse sets its status bit on the next clock edge whether or not the matching enable is set.
- R3: Writing a mask to a channel's status select (code 2) clears exactly the bits that are set in the mask. Status bits never clear without such a write.
- R4: When a cause pulse and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R5: Summary bit n is set when channel n has a status bit set whose enable is also set. Copy-done and watermark bits are gated by the host enable. Error bits are gated by the auxiliary enable.
- R6: `irq` is registered. In each cycle it equals the OR of the summary word from the previous cycle.
- R7: The host enable register stores only the copy-done and watermark positions. The auxiliary enable register stores only the error positions. All other bits read as 0.
- R8: Once every enable of every channel is 0, `irq` is 0 from the next cycle on, and the latched status is kept.
- R9: Select code 3 reads the summary word for any channel field. Writes to it change nothing.
- R10: A channel field at or above NUM_CH selects no register. Writes there are ignored and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| addr | input | CH_AW+2 | {channel, select} |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational read data |
| causeCopy | input | NUM_CH | Copy-done cause pulse, one per channel |
| causeWm | input | NUM_CH*WM_W | Watermark cause pulses, channel-major |
| causeErr | input | NUM_CH*ERR_W | Error cause pulses, channel-major |
| summary | output | NUM_CH | Per-channel pending-interrupt word |
| irq | output | 1 | Registered combined interrupt |

## Verification
A status bit can be set by its cause pulse and cleared by a software write in the same cycle. The bench provokes this by driving an error pulse for channel 2 together with a write-one-to-clear of that same bit. The bit must read back as set afterward. A second clearing write without the pulse must then remove the bit, which shows that the clear path works on its own.

// File: rtl/intr_agg_pkg.sv
package intr_agg_pkg;
  localparam logic [1:0] SEL_HOST_EN = 2'd0;
  localparam logic [1:0] SEL_AUX_EN  = 2'd1;
  localparam logic [1:0] SEL_STATUS  = 2'd2;
  localparam logic [1:0] SEL_SUMMARY = 2'd3;

  typedef struct packed {
    logic hostWr;
    logic auxWr;
    logic statClr;
    logic chOk;
    logic sumSel;
  } strobe_t;
endpackage

// File: rtl/intr_agg_ctrl.sv
module intr_agg_ctrl
  import intr_agg_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CH_AW  = 3
) (
  input  logic             wrEn,
  input  logic [CH_AW+1:0] addr,
  output strobe_t          strb,
  output logic [CH_AW-1:0] chIdx,
  output logic [1:0]       regSel
);
  logic chOk;

  assign chIdx  = addr[CH_AW+1:2];
  assign regSel = addr[1:0];
  assign chOk   = int'(chIdx) < NUM_CH;

  always_comb begin
    strb         = '0;
    strb.chOk    = chOk;
    strb.sumSel  = (regSel == SEL_SUMMARY);
    strb.hostWr  = wrEn && chOk && (regSel == SEL_HOST_EN);
    strb.auxWr   = wrEn && chOk && (regSel == SEL_AUX_EN);
    strb.statClr = wrEn && chOk && (regSel == SEL_STATUS);
  end
endmodule

// File: rtl/intr_agg_dp.sv
module intr_agg_dp
  import intr_agg_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CH_AW  = 3,
  parameter int WM_W   = 4,
  parameter int ERR_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   strb,
  input  logic [CH_AW-1:0]          chIdx,
  input  logic [1:0]                regSel,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [NUM_CH-1:0]         causeCopy,
  input  logic [NUM_CH*WM_W-1:0]    causeWm,
  input  logic [NUM_CH*ERR_W-1:0]   causeErr,
  output logic [DATA_W-1:0]         rdata,
  output logic [NUM_CH-1:0]         summary,
  output logic                      irq,
  output logic [NUM_CH*(1+WM_W+ERR_W)-1:0] statusFlat,
  output logic [NUM_CH*(1+WM_W+ERR_W)-1:0] enableFlat
);
  localparam int STAT_W = 1 + WM_W + ERR_W;
  localparam logic [STAT_W-1:0] HOST_MASK = {{ERR_W{1'b0}}, {(WM_W+1){1'b1}}};
  localparam logic [STAT_W-1:0] AUX_MASK  = ~HOST_MASK;

  logic [STAT_W-1:0] hostArr [NUM_CH];
  logic [STAT_W-1:0] auxArr  [NUM_CH];
  logic [STAT_W-1:0] statArr [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic              chHit;
    logic [STAT_W-1:0] causeVec;
    logic [STAT_W-1:0] clrMask;
    logic [STAT_W-1:0] hostEn, auxEn, stat;

    assign chHit    = (int'(chIdx) == ch);
    assign causeVec = {causeErr[ch*ERR_W +: ERR_W], causeWm[ch*WM_W +: WM_W], causeCopy[ch]};
    assign clrMask  = (strb.statClr && chHit) ? wdata[STAT_W-1:0] : '0;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        hostEn <= '0;
        auxEn  <= '0;
        stat   <= '0;
      end else begin
        if (strb.hostWr && chHit) hostEn <= wdata[STAT_W-1:0] & HOST_MASK;
        if (strb.auxWr && chHit)  auxEn  <= wdata[STAT_W-1:0] & AUX_MASK;
        stat <= (stat & ~clrMask) | causeVec;
      end
    end

    assign summary[ch] = |(stat & (hostEn | auxEn));
    assign hostArr[ch] = hostEn;
    assign auxArr[ch]  = auxEn;
    assign statArr[ch] = stat;
    assign statusFlat[ch*STAT_W +: STAT_W] = stat;
    assign enableFlat[ch*STAT_W +: STAT_W] = hostEn | auxEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= |summary;
  end

  always_comb begin
    rdata = '0;
    if (strb.sumSel) begin
      rdata[NUM_CH-1:0] = summary;
    end else if (strb.chOk) begin
      case (regSel)
        SEL_HOST_EN: rdata[STAT_W-1:0] = hostArr[chIdx];
        SEL_AUX_EN:  rdata[STAT_W-1:0] = auxArr[chIdx];
        default:     rdata[STAT_W-1:0] = statArr[chIdx];
      endcase
    end
  end
endmodule

// File: rtl/intr_aggregator.sv
module intr_aggregator
  import intr_agg_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CH_AW  = 3,
  parameter int WM_W   = 4,
  parameter int ERR_W  = 3,
  localparam int STAT_W = 1 + WM_W + ERR_W,
  localparam int DATA_W = (STAT_W > NUM_CH) ? STAT_W : NUM_CH
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [CH_AW+1:0]        addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rdata,
  input  logic [NUM_CH-1:0]       causeCopy,
  input  logic [NUM_CH*WM_W-1:0]  causeWm,
  input  logic [NUM_CH*ERR_W-1:0] causeErr,
  output logic [NUM_CH-1:0]       summary,
  output logic                    irq
);
  strobe_t                    strb;
  logic [CH_AW-1:0]           chIdx;
  logic [1:0]                 regSel;
  logic [NUM_CH*STAT_W-1:0]   statusFlat;
  logic [NUM_CH*STAT_W-1:0]   enableFlat;

  intr_agg_ctrl #(.NUM_CH(NUM_CH), .CH_AW(CH_AW)) i_ctrl (
    .wrEn(wrEn), .addr(addr), .strb(strb), .chIdx(chIdx), .regSel(regSel)
  );

  intr_agg_dp #(
    .NUM_CH(NUM_CH), .CH_AW(CH_AW), .WM_W(WM_W), .ERR_W(ERR_W), .DATA_W(DATA_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .chIdx(chIdx), .regSel(regSel),
    .wdata(wdata), .causeCopy(causeCopy), .causeWm(causeWm), .causeErr(causeErr),
    .rdata(rdata), .summary(summary), .irq(irq),
    .statusFlat(statusFlat), .enableFlat(enableFlat)
  );
endmodule

// File: rtl/intr_agg_chk.sv
module intr_agg_chk #(
  parameter int NUM_CH = 6,
  parameter int WM_W   = 4,
  parameter int ERR_W  = 3,
  localparam int STAT_W = 1 + WM_W + ERR_W
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    wrEn,
  input logic [NUM_CH-1:0]       causeCopy,
  input logic [NUM_CH*WM_W-1:0]  causeWm,
  input logic [NUM_CH*ERR_W-1:0] causeErr,
  input logic [NUM_CH-1:0]       summary,
  input logic                    irq,
  input logic [NUM_CH*STAT_W-1:0] statusFlat,
  input logic [NUM_CH*STAT_W-1:0] enableFlat
);
  logic [NUM_CH*STAT_W-1:0] causeFlat;
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cause
    assign causeFlat[ch*STAT_W +: STAT_W] =
      {causeErr[ch*ERR_W +: ERR_W], causeWm[ch*WM_W +: WM_W], causeCopy[ch]};
  end

  p_irq_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (|summary) |=> irq);
  p_irq_clr_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(|summary) |=> !irq);
  p_cause_latch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (|causeFlat) |=> ((statusFlat & $past(causeFlat)) == $past(causeFlat)));
  p_clear_needs_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ((statusFlat & $past(statusFlat)) == $past(statusFlat)));
  p_silent_r8: assert property (@(posedge clk) disable iff (!rstN)
    (enableFlat == '0) |=> !irq);
endmodule

bind intr_aggregator intr_agg_chk #(.NUM_CH(NUM_CH), .WM_W(WM_W), .ERR_W(ERR_W)) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .causeCopy(causeCopy), .causeWm(causeWm),
  .causeErr(causeErr), .summary(summary), .irq(irq),
  .statusFlat(statusFlat), .enableFlat(enableFlat)
);

// File: tb/test_intr_aggregator.sv
module test_intr_aggregator;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [5:0]  causeCopy = '0;
  logic [23:0] causeWm = '0;
  logic [17:0] causeErr = '0;
  logic [5:0]  summary;
  logic        irq;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 0;

  always #2.5 clk = ~clk;

  intr_aggregator i_intr_aggregator (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata), .rdata(rdata),
    .causeCopy(causeCopy), .causeWm(causeWm), .causeErr(causeErr),
    .summary(summary), .irq(irq)
  );

  typedef struct packed {
    logic       isRd;
    logic [4:0] a;
    logic [7:0] d;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{1'b0, 5'h04, 8'hFF, 8'h00},
    '{1'b1, 5'h04, 8'h00, 8'h1F},  // R7 host enable keeps copy/watermark bits only
    '{1'b0, 5'h05, 8'hFF, 8'h00},
    '{1'b1, 5'h05, 8'h00, 8'hE0},  // R7 aux enable keeps error bits only
    '{1'b0, 5'h1C, 8'hFF, 8'h00},
    '{1'b1, 5'h1C, 8'h00, 8'h00},  // R10 channel 7 does not exist
    '{1'b0, 5'h0F, 8'hFF, 8'h00},
    '{1'b1, 5'h03, 8'h00, 8'h00},  // R9 summary write has no effect
    '{1'b0, 5'h04, 8'h00, 8'h00},
    '{1'b0, 5'h05, 8'h00, 8'h00},
    '{1'b1, 5'h04, 8'h00, 8'h00}   // R7 host enable cleared again
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [4:0] a, input logic [7:0] d,
                      input logic [5:0] cc, input logic [23:0] cw, input logic [17:0] ce);
    @(negedge clk);
    wrEn = wr; addr = a; wdata = d; causeCopy = cc; causeWm = cw; causeErr = ce;
    @(negedge clk);
    wrEn = 1'b0; causeCopy = '0; causeWm = '0; causeErr = '0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    step(1'b1, a, d, '0, '0, '0);
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int ch = 0; ch < 6; ch++) begin
      for (int s = 0; s < 3; s++) begin
        rd({ch[2:0], s[1:0]}, v);
        chk("R1 register after reset", v, 8'h00);
      end
    end
    chk("R1 summary after reset", {2'b0, summary}, 8'h00);
    chk("R1 irq after reset", {7'b0, irq}, 8'h00);

    // table walk: enable masking, summary write, missing channel
    for (int i = 0; i < 11; i++) begin
      if (VECS[i].isRd) begin
        rd(VECS[i].a, v);
        chk("R7/R9/R10 table", v, VECS[i].exp);
      end else begin
        wr(VECS[i].a, VECS[i].d);
      end
    end

    // R2 cause latches with enables off
    step(1'b0, 5'h00, 8'h00, 6'b000100, '0, '0);
    rd(5'h0A, v);
    chk("R2 copy cause latched without enable", v, 8'h01);
    chk("R5 summary gated by disabled enable", {2'b0, summary}, 8'h00);
    chk("R6 irq idle", {7'b0, irq}, 8'h00);

    // R5 / R6 enable copy-done on channel 2
    wr(5'h08, 8'h01);
    chk("R5 summary after host enable", {2'b0, summary}, 8'h04);
    chk("R6 irq lags summary by one cycle", {7'b0, irq}, 8'h00);
    @(negedge clk);
    chk("R6 irq follows summary", {7'b0, irq}, 8'h01);

    // R3 selective clear
    step(1'b0, 5'h00, 8'h00, '0, 24'h000200, 18'h00080);
    rd(5'h0A, v);
    chk("R2 watermark and error latched", v, 8'h45);
    wr(5'h0A, 8'h04);
    rd(5'h0A, v);
    chk("R3 clear exactly the masked bit", v, 8'h41);

    // R5 error gating by aux enable
    wr(5'h08, 8'h00);
    chk("R5 copy bit gated off, error not enabled", {2'b0, summary}, 8'h00);
    wr(5'h09, 8'hE0);
    chk("R5 error bit gated by aux enable", {2'b0, summary}, 8'h04);

    // R4 pulse and clear collide
    step(1'b1, 5'h0A, 8'h40, '0, '0, 18'h00080);
    rd(5'h0A, v);
    chk("R4 cause wins over same-cycle clear", v, 8'h41);
    wr(5'h0A, 8'h40);
    rd(5'h0A, v);
    chk("R3 clear without collision", v, 8'h01);
    chk("R5 summary drops after error cleared", {2'b0, summary}, 8'h00);

    // ascending service of two channels
    step(1'b0, 5'h00, 8'h00, 6'b010001, '0, '0);
    wr(5'h00, 8'h01);
    wr(5'h10, 8'h01);
    chk("R5 two channels pending", {2'b0, summary}, 8'h11);
    rd(5'h13, v);
    chk("R9 summary read through channel 4 field", v, 8'h11);
    wr(5'h02, 8'h01);
    chk("R3 channel 0 serviced first", {2'b0, summary}, 8'h10);
    wr(5'h12, 8'h01);
    chk("R5 all serviced", {2'b0, summary}, 8'h00);
    chk("R6 irq still high for one cycle", {7'b0, irq}, 8'h01);
    @(negedge clk);
    chk("R6 irq drops", {7'b0, irq}, 8'h00);

    // R8 global disable silences irq, status retained
    step(1'b0, 5'h00, 8'h00, 6'b001000, '0, 18'h08000);
    wr(5'h0C, 8'h1F);
    wr(5'h15, 8'hE0);
    @(negedge clk);
    chk("R5 channels 3 and 5 pending", {2'b0, summary}, 8'h28);
    chk("R6 irq raised", {7'b0, irq}, 8'h01);
    for (int ch = 0; ch < 6; ch++) begin
      wr({ch[2:0], 2'd0}, 8'h00);
      wr({ch[2:0], 2'd1}, 8'h00);
    end
    chk("R8 summary silent", {2'b0, summary}, 8'h00);
    @(negedge clk);
    chk("R8 irq silent", {7'b0, irq}, 8'h00);
    rd(5'h0E, v);
    chk("R8 channel 3 status kept", v, 8'h01);
    rd(5'h16, v);
    chk("R8 channel 5 status kept", v, 8'h20);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule